// File: doc/BRIEF.md
# Bus Event Pattern Monitor

This block sits inline between an untrusted processing element and a shared interconnect. Every transfer the element issues, read or write, enters the monitor and leaves it one clock later on a gated output port, so no transfer can reach the bus without passing the check. Two programmable events are defined, each as a write of a given data value to a given address. The monitor requires these events to form the repeating pattern "first, second, first, second, ...", starting with the first.

A matched event that is not the one the pattern expects is a violation. The monitor then applies one recovery action, chosen by a 2-bit selector. It can drop the offending write, stop the process with a sticky request, reset the process with a one-cycle pulse, or replace the offending write with a fixed word. A completed pair is reported on a validation pulse, and a violation on a violation pulse.

The pattern tracker has two states. ST_WANT_FIRST is the state after reset and ST_WANT_SECOND follows it. The transitions are:
- ADVANCE: the first event while in ST_WANT_FIRST moves to ST_WANT_SECOND.
- COMPLETE: the second event while in ST_WANT_SECOND moves back to ST_WANT_FIRST and raises the validation pulse.
- VIOLATE: an out-of-order event keeps the current state, except under the reset action.
- RECOVER: under the reset action, a violation forces ST_WANT_FIRST.

A separate stop flag halts all traffic while it is set.

Top module: `evmon_top`

## Requirements
- R1: While reset is asserted and right after it, the monitor is quiet and the pattern state is ST_WANT_FIRST. Quiet means out_vld, stop_req, rst_req, viol and pair_ok are all 0.
- R2: An event is a write (in_vld=1, in_wr=1) whose address and data both equal the configured pair for that event. A read, or a write that differs in address or data, is never an event.
- R3: Events in the expected order are forwarded unchanged one cycle after they are presented. The first event moves the state to ST_WANT_SECOND. The second event moves it back to ST_WANT_FIRST and raises pair_ok for one cycle, in the same cycle as the forwarded transfer.
- R4: A matched event that the current state does not expect raises viol for exactly one cycle, one cycle after the transfer. viol and pair_ok are never high together.
- R5: A transfer that is not an event appears one cycle later on the output with identical valid, direction, address and data. It leaves the pattern state unchanged.
- R6: With act_sel=0 (reject), the offending write produces no output transfer (out_vld=0) and the pattern state is unchanged.
- R7: With act_sel=1 (stop), the offending write is dropped and stop_req rises and stays high until stop_clr is seen. While stop_req is high, every transfer is blocked and no event is evaluated. The clear takes effect at the next edge, and a transfer presented in the same cycle as stop_clr is still blocked.
- R8: With act_sel=2 (reset), the offending write is dropped, rst_req pulses for one cycle together with viol, and the pattern state returns to ST_WANT_FIRST.
- R9: With act_sel=3 (inject), the offending write is replaced on the output by a write of inj_data to inj_addr, and the pattern state is unchanged.
- R10: A write that matches both configured events counts as whichever event the current state expects, and so it is in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Incoming transfer valid |
| in_wr | input | 1 | Incoming transfer is a write (1) or read (0) |
| in_addr | input | AW | Incoming transfer address |
| in_data | input | DW | Incoming transfer data |
| ev1_addr | input | AW | Address of the first event |
| ev1_data | input | DW | Data value of the first event |
| ev2_addr | input | AW | Address of the second event |
| ev2_data | input | DW | Data value of the second event |
| act_sel | input | 2 | Recovery action: 0 reject, 1 stop, 2 reset, 3 inject |
| inj_addr | input | AW | Address of the injected write |
| inj_data | input | DW | Data of the injected write |
| stop_clr | input | 1 | Clears a pending stop request |
| out_vld | output | 1 | Forwarded transfer valid |
| out_wr | output | 1 | Forwarded transfer direction |
| out_addr | output | AW | Forwarded transfer address |
| out_data | output | DW | Forwarded transfer data |
| stop_req | output | 1 | Sticky stop request to the monitored process |
| rst_req | output | 1 | One-cycle reset request to the monitored process |
| viol | output | 1 | One-cycle violation pulse |
| pair_ok | output | 1 | One-cycle validation pulse on a completed pair |

## Verification
A pattern state that is wrong is hidden until the next matched event arrives. At that point it shows, one cycle after the event, as a viol pulse where pair_ok or a clean forward was due, or the reverse. For this reason the stimulus follows every recovery with an in-order event that exposes where the state was left. A stop flag that is wrong shows one cycle later as a dropped or leaked transfer on out_vld. The scoreboard compares every output on every cycle, so such a leak is caught in the first cycle it happens.

// File: rtl/evmon_pkg.sv
package evmon_pkg;

    // Recovery action selector codes
    typedef enum logic [1:0] {
        ACT_REJECT = 2'd0,
        ACT_STOP   = 2'd1,
        ACT_RESET  = 2'd2,
        ACT_INJECT = 2'd3
    } act_e;

    // Pattern tracker states
    typedef enum logic {
        ST_WANT_FIRST  = 1'b0,
        ST_WANT_SECOND = 1'b1
    } pat_e;

    // Per-cycle decision handed from tracker to output stage
    typedef struct packed {
        logic fwd;   // pass the incoming transfer if it is valid
        logic inj;   // replace it with the injected word
        logic viol;  // violation detected this cycle
        logic pair;  // pair completed this cycle
        logic rst;   // reset request this cycle
    } verdict_t;

endpackage

// File: rtl/evmon_match.sv
module evmon_match #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          vld,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    input  logic [AW-1:0] ref_addr,
    input  logic [DW-1:0] ref_data,
    output logic          hit
);
    // Only writes can be events; reads never match.
    always_comb begin
        hit = vld && wr && (addr == ref_addr) && (data == ref_data);
    end
endmodule

// File: rtl/evmon_fsm.sv
module evmon_fsm
    import evmon_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] hit,
    input  act_e       action,
    input  logic       stop_clr,
    output verdict_t   verdict,
    output logic       stop_req,
    output logic       rst_req,
    output logic       viol,
    output logic       pair_ok
);
    pat_e st, st_n;
    logic stop_n;
    logic in_ord;
    logic any_hit;

    assign any_hit = |hit;
    assign in_ord  = (st == ST_WANT_FIRST) ? hit[0] : hit[1];

    // Next-state process
    always_comb begin
        st_n   = st;
        stop_n = stop_req;
        if (stop_req) begin
            if (stop_clr) stop_n = 1'b0;
        end else if (any_hit) begin
            if (in_ord) begin
                unique case (st)
                    ST_WANT_FIRST:  st_n = ST_WANT_SECOND;  // ADVANCE
                    ST_WANT_SECOND: st_n = ST_WANT_FIRST;   // COMPLETE
                endcase
            end else begin
                unique case (action)
                    ACT_REJECT: st_n = st;
                    ACT_STOP:   stop_n = 1'b1;
                    ACT_RESET:  st_n = ST_WANT_FIRST;       // RECOVER
                    ACT_INJECT: st_n = st;
                endcase
            end
        end
    end

    // Output decision process
    always_comb begin
        verdict     = '0;
        verdict.fwd = !stop_req;
        if (!stop_req && any_hit) begin
            if (in_ord) begin
                verdict.pair = (st == ST_WANT_SECOND);
            end else begin
                verdict.fwd  = 1'b0;
                verdict.viol = 1'b1;
                unique case (action)
                    ACT_REJECT: verdict.inj = 1'b0;
                    ACT_STOP:   verdict.inj = 1'b0;
                    ACT_RESET:  verdict.rst = 1'b1;
                    ACT_INJECT: verdict.inj = 1'b1;
                endcase
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_WANT_FIRST;
            stop_req <= 1'b0;
            rst_req  <= 1'b0;
            viol     <= 1'b0;
            pair_ok  <= 1'b0;
        end else begin
            st       <= st_n;
            stop_req <= stop_n;
            rst_req  <= verdict.rst;
            viol     <= verdict.viol;
            pair_ok  <= verdict.pair;
        end
    end

    // R7: stop request holds until cleared
    p_stop_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req && !stop_clr |=> stop_req);

    // R8: a reset request leaves the tracker at its home state and flags the violation
    p_reset_home_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (st == ST_WANT_FIRST) && viol);

    // R4: validation and violation are exclusive
    p_one_outcome_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({viol, pair_ok}));

    // R6: rejecting leaves the pattern state alone
    p_reject_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_req && any_hit && !in_ord && action == ACT_REJECT |=> st == $past(st));
endmodule

// File: rtl/evmon_gate.sv
module evmon_gate #(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic          in_wr,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_data,
    input  logic          fwd,
    input  logic          inj,
    input  logic [AW-1:0] inj_addr,
    input  logic [DW-1:0] inj_data,
    output logic          out_vld,
    output logic          out_wr,
    output logic [AW-1:0] out_addr,
    output logic [DW-1:0] out_data
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_wr   <= 1'b0;
            out_addr <= '0;
            out_data <= '0;
        end else if (inj) begin
            out_vld  <= 1'b1;
            out_wr   <= 1'b1;
            out_addr <= inj_addr;
            out_data <= inj_data;
        end else begin
            out_vld  <= in_vld && fwd;
            out_wr   <= in_wr;
            out_addr <= in_addr;
            out_data <= in_data;
        end
    end
endmodule

// File: rtl/evmon_top.sv
module evmon_top
    import evmon_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic          in_wr,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_data,
    input  logic [AW-1:0] ev1_addr,
    input  logic [DW-1:0] ev1_data,
    input  logic [AW-1:0] ev2_addr,
    input  logic [DW-1:0] ev2_data,
    input  logic [1:0]    act_sel,
    input  logic [AW-1:0] inj_addr,
    input  logic [DW-1:0] inj_data,
    input  logic          stop_clr,
    output logic          out_vld,
    output logic          out_wr,
    output logic [AW-1:0] out_addr,
    output logic [DW-1:0] out_data,
    output logic          stop_req,
    output logic          rst_req,
    output logic          viol,
    output logic          pair_ok
);
    localparam int EV_CNT = 2;

    logic [AW-1:0]     ev_addr [EV_CNT];
    logic [DW-1:0]     ev_data [EV_CNT];
    logic [EV_CNT-1:0] hit;
    verdict_t          verdict;

    assign ev_addr[0] = ev1_addr;
    assign ev_addr[1] = ev2_addr;
    assign ev_data[0] = ev1_data;
    assign ev_data[1] = ev2_data;

    for (genvar g = 0; g < EV_CNT; g++) begin : g_match
        evmon_match #(.AW(AW), .DW(DW)) i_match (
            .vld      (in_vld),
            .wr       (in_wr),
            .addr     (in_addr),
            .data     (in_data),
            .ref_addr (ev_addr[g]),
            .ref_data (ev_data[g]),
            .hit      (hit[g])
        );
    end

    evmon_fsm i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .action   (act_e'(act_sel)),
        .stop_clr (stop_clr),
        .verdict  (verdict),
        .stop_req (stop_req),
        .rst_req  (rst_req),
        .viol     (viol),
        .pair_ok  (pair_ok)
    );

    evmon_gate #(.AW(AW), .DW(DW)) i_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (in_vld),
        .in_wr    (in_wr),
        .in_addr  (in_addr),
        .in_data  (in_data),
        .fwd      (verdict.fwd),
        .inj      (verdict.inj),
        .inj_addr (inj_addr),
        .inj_data (inj_data),
        .out_vld  (out_vld),
        .out_wr   (out_wr),
        .out_addr (out_addr),
        .out_data (out_data)
    );

    // R7: nothing leaves the block while stopped
    p_stop_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> !out_vld);

    // R5: non-event traffic is passed through untouched
    p_plain_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld && !(|hit) && !stop_req |=> out_vld && out_wr == $past(in_wr)
            && out_addr == $past(in_addr) && out_data == $past(in_data));
endmodule

// File: tb/test_evmon_top.sv
module test_evmon_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_vld = 1'b0, in_wr = 1'b0, stop_clr = 1'b0;
    logic [AW-1:0] in_addr = '0;
    logic [DW-1:0] in_data = '0;
    logic [AW-1:0] ev1_addr = 16'h0010, ev2_addr = 16'h0014, inj_addr = 16'h003C;
    logic [DW-1:0] ev1_data = 32'd101, ev2_data = 32'h2A, inj_data = 32'hDEAD;
    logic [1:0]    act_sel = 2'd0;
    logic          out_vld, out_wr, stop_req, rst_req, viol, pair_ok;
    logic [AW-1:0] out_addr;
    logic [DW-1:0] out_data;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    typedef struct {
        logic          vld, wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          stop, rst, vio, pair;
        string         tag;
    } exp_t;
    exp_t sb[$];

    // independent model state
    bit m_want_second = 0;
    bit m_stop = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evmon_top #(.AW(AW), .DW(DW)) i_evmon_top (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_wr(in_wr),
        .in_addr(in_addr), .in_data(in_data),
        .ev1_addr(ev1_addr), .ev1_data(ev1_data),
        .ev2_addr(ev2_addr), .ev2_data(ev2_data),
        .act_sel(act_sel), .inj_addr(inj_addr), .inj_data(inj_data),
        .stop_clr(stop_clr), .out_vld(out_vld), .out_wr(out_wr),
        .out_addr(out_addr), .out_data(out_data), .stop_req(stop_req),
        .rst_req(rst_req), .viol(viol), .pair_ok(pair_ok)
    );

    task automatic step(input logic v, input logic w, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic clr, input string tag);
        exp_t e;
        bit m1, m2, hit, ord;
        @(negedge clk);
        in_vld = v; in_wr = w; in_addr = a; in_data = d; stop_clr = clr;
        m1 = v && w && a == ev1_addr && d == ev1_data;
        m2 = v && w && a == ev2_addr && d == ev2_data;
        e.vld = 0; e.wr = w; e.addr = a; e.data = d;
        e.rst = 0; e.vio = 0; e.pair = 0; e.tag = tag;
        if (m_stop) begin
            if (clr) m_stop = 0;
        end else begin
            hit = m1 || m2;
            ord = m_want_second ? m2 : m1;
            if (!hit) e.vld = v;
            else if (ord) begin
                e.vld = 1;
                e.pair = m_want_second;
                m_want_second = !m_want_second;
            end else begin
                e.vio = 1;
                case (act_sel)
                    2'd1: m_stop = 1;
                    2'd2: begin e.rst = 1; m_want_second = 0; end
                    2'd3: begin e.vld = 1; e.wr = 1; e.addr = inj_addr; e.data = inj_data; end
                    default: ;
                endcase
            end
        end
        e.stop = m_stop;
        sb.push_back(e);
    endtask

    // scoreboard monitor
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            bit bad;
            e = sb.pop_front();
            n_chk++;
            bad = out_vld !== e.vld || stop_req !== e.stop || rst_req !== e.rst
                  || viol !== e.vio || pair_ok !== e.pair;
            if (e.vld && (out_wr !== e.wr || out_addr !== e.addr || out_data !== e.data))
                bad = 1;
            if (bad) begin
                n_err++;
                $display("FAIL %s: got vld=%b wr=%b a=%h d=%h stop=%b rst=%b viol=%b pair=%b exp vld=%b wr=%b a=%h d=%h stop=%b rst=%b viol=%b pair=%b",
                         e.tag, out_vld, out_wr, out_addr, out_data, stop_req, rst_req, viol, pair_ok,
                         e.vld, e.wr, e.addr, e.data, e.stop, e.rst, e.vio, e.pair);
            end
        end
    end

    task automatic wrap_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: got running exp finished");
            wrap_up();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        n_chk++;  // R1 reset state
        if (out_vld !== 0 || stop_req !== 0 || rst_req !== 0 || viol !== 0 || pair_ok !== 0) begin
            n_err++;
            $display("FAIL R1: got vld=%b stop=%b rst=%b viol=%b pair=%b exp all 0",
                     out_vld, stop_req, rst_req, viol, pair_ok);
        end
        rst_n = 1;
        // reject action
        act_sel = 2'd0;
        step(0, 0, 16'h0000, 32'h0, 0, "R1 idle after reset");
        step(1, 1, 16'h0020, 32'h5, 0, "R5 plain write");
        step(1, 0, 16'h0010, 32'd101, 0, "R2 read of event address");
        step(1, 1, 16'h0010, 32'd102, 0, "R2 wrong data");
        step(1, 1, 16'h0010, 32'd101, 0, "R3 first event");
        step(1, 0, 16'h0044, 32'h7, 0, "R5 read between events");
        step(1, 1, 16'h0014, 32'h2A, 0, "R3 second event pair");
        step(1, 1, 16'h0014, 32'h2A, 0, "R6 reject out-of-order");
        step(1, 1, 16'h0010, 32'd101, 0, "R6 state kept after reject");
        step(1, 1, 16'h0010, 32'd101, 0, "R4 repeated first event");
        step(1, 1, 16'h0014, 32'h2A, 0, "R3 pair after reject");
        // inject action
        act_sel = 2'd3;
        step(1, 1, 16'h0014, 32'h2A, 0, "R9 inject replaces write");
        step(1, 1, 16'h0010, 32'd101, 0, "R9 state kept after inject");
        // reset action
        act_sel = 2'd2;
        step(1, 1, 16'h0010, 32'd101, 0, "R8 reset on violation");
        step(1, 1, 16'h0010, 32'd101, 0, "R8 state back to first");
        step(1, 1, 16'h0014, 32'h2A, 0, "R8 pair after reset");
        // stop action
        act_sel = 2'd1;
        step(1, 1, 16'h0014, 32'h2A, 0, "R7 stop on violation");
        step(1, 1, 16'h0020, 32'h9, 0, "R7 plain write blocked");
        step(1, 1, 16'h0010, 32'd101, 0, "R7 event ignored while stopped");
        step(1, 0, 16'h0020, 32'h0, 1, "R7 clear, transfer still blocked");
        step(1, 1, 16'h0010, 32'd101, 0, "R7 resumed first event");
        step(0, 1, 16'h0010, 32'd101, 1, "R7 clear without stop has no effect");
        // both configured events identical
        act_sel = 2'd0;
        @(negedge clk);
        ev2_addr = 16'h0010; ev2_data = 32'd101;
        step(1, 1, 16'h0010, 32'd101, 0, "R10 dual match taken as second");
        step(1, 1, 16'h0010, 32'd101, 0, "R10 dual match taken as first");
        step(0, 0, 16'h0000, 32'h0, 0, "R5 idle flush");
        step(0, 0, 16'h0000, 32'h0, 0, "R5 idle flush");
        wait (sb.size() == 0);
        @(negedge clk);
        done = 1;
        wrap_up();
    end
endmodule